// File: doc/BRIEF.md
# Three-Bank Edge-Aligned Clock Divider

The block turns one fast source clock into three banks of slower clocks. Every clock in every bank shares its rising edges with the others. A range select puts an optional divide-by-two stage in front of all three banks. Each bank then divides that stage's output by one of two even ratios, chosen by its own select input. Every copy inside a bank comes from the same internal register.

A single active-high reset/disable input does two jobs. Whenever it is high, it releases the tristate enables of every output at once. If it stays high across more than two reference clock cycles, it also clears every divider and reloads the range and bank selects. Selects are loaded only while that qualified reset lasts, so changing them during operation has no effect. After reset is released, all bank counters start together from zero.

A bypass input swaps the reference clock in for the fast source. In bypass the banks output divided copies of the reference clock, which is useful for static test.

Top module: `bank_clk_divider`

## Requirements
- R1: With the captured range select at 0, every bank counts one tick per work clock cycle; with it at 1, a tick occurs on every second work clock cycle.
- R2: Bank A drives five identical outputs at the tick rate divided by 4 when its captured select is 0 and by 6 when it is 1.
- R3: Bank B drives four identical outputs at the tick rate divided by 4 when its captured select is 0 and by 2 when it is 1.
- R4: Bank C drives two identical outputs at the tick rate divided by 2 when its captured select is 0 and by 4 when it is 1.
- R5: A bank dividing by N is high for N/2 ticks and then low for N/2 ticks, and changes level only on a tick.
- R6: After reset release, all three banks go high on the same first tick and keep going high together whenever their ratios allow.
- R7: While rst_dis is high, all output enables are 0 with no delay; once the reset qualifies, all bank clocks are held low.
- R8: The dividers restart only after rst_dis is seen high on three consecutive reference clock rising edges; a pulse seen on two edges or fewer leaves the bank clocks running undisturbed.
- R9: With bypass at 1, the reference clock replaces the fast source as the work clock, so the bank clocks are divided copies of the reference.
- R10: The range and bank selects are loaded only while the qualified reset lasts, so all-zero inputs give ratios 4, 4 and 2 with no pre-division; changes outside reset have no effect until the next qualified reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Fast source clock |
| ref_clk | input | 1 | Reference clock; times the reset and replaces the source in bypass |
| bypass | input | 1 | 1 selects the reference clock as the work clock |
| range_sel | input | 1 | 1 inserts the divide-by-two pre-stage |
| sel_a | input | 1 | Bank A ratio select (0: 4, 1: 6) |
| sel_b | input | 1 | Bank B ratio select (0: 4, 1: 2) |
| sel_c | input | 1 | Bank C ratio select (0: 2, 1: 4) |
| rst_dis | input | 1 | Active-high reset and output disable |
| qa | output | 5 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 2 | Bank C clocks |
| oe_a | output | 5 | Tristate enables for bank A |
| oe_b | output | 4 | Tristate enables for bank B |
| oe_c | output | 2 | Tristate enables for bank C |

## Verification
The checks assume that bypass changes only while a qualified reset is held. The work clock is switched by a plain multiplexer, so a change during operation could clip a clock pulse. They also assume that rst_dis is driven in step with the reference clock, so that every pulse covers a definite number of its rising edges. The stimulus changes bypass only inside a long reset. It drives rst_dis on falling edges of the reference clock, holding it for either six cycles or exactly two. Select changes made during operation are free to land on any work cycle, because the block is required to ignore them.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int BANK_A_OUTS = 5;
    localparam int BANK_B_OUTS = 4;
    localparam int BANK_C_OUTS = 2;

    localparam int BANK_A_LO = 4;
    localparam int BANK_A_HI = 6;
    localparam int BANK_B_LO = 4;
    localparam int BANK_B_HI = 2;
    localparam int BANK_C_LO = 2;
    localparam int BANK_C_HI = 4;

    typedef struct packed {
        logic range;
        logic sel_a;
        logic sel_b;
        logic sel_c;
    } cfg_t;

    function automatic int pick_div(logic sel, int lo, int hi);
        return sel ? hi : lo;
    endfunction

    function automatic logic divides(int small_div, int big_div);
        return (big_div % small_div) == 0;
    endfunction

endpackage

// File: rtl/bcd_rst_qual.sv
module bcd_rst_qual #(
    parameter int HOLD = 3
) (
    input  logic ref_clk,
    input  logic rst_in,
    output logic qual
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] run;

    always_ff @(posedge ref_clk) begin
        if (!rst_in) begin
            run  <= '0;
            qual <= 1'b0;
        end else begin
            if (run < CW'(HOLD - 1))
                run <= run + 1'b1;
            qual <= (run == CW'(HOLD - 1));
        end
    end

    // R8
    qual_needs_held_input_chk: assert property (@(posedge ref_clk)
        $rose(qual) |-> ($past(rst_in, 1) && $past(rst_in, 2)));

endmodule

// File: rtl/bcd_bank.sv
module bcd_bank #(
    parameter int OUTS   = 5,
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            sel,
    output logic            level,
    output logic [OUTS-1:0] q
);
    localparam int MAXD = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [CW-1:0] half;

    assign lim  = sel ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    assign half = sel ? CW'(DIV_HI / 2) : CW'(DIV_LO / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (tick) begin
            level <= (cnt < half);
            cnt   <= (cnt == lim) ? '0 : cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < OUTS; i++) begin : g_copy
        assign q[i] = level;
    end

    // R5
    level_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(level));

    // R7
    level_low_in_reset_chk: assert property (@(posedge clk)
        rst |=> !level);

endmodule

// File: rtl/bank_clk_divider.sv
module bank_clk_divider
    import bcd_pkg::*;
#(
    parameter int A_OUTS      = BANK_A_OUTS,
    parameter int B_OUTS      = BANK_B_OUTS,
    parameter int C_OUTS      = BANK_C_OUTS,
    parameter int A_LO        = BANK_A_LO,
    parameter int A_HI        = BANK_A_HI,
    parameter int B_LO        = BANK_B_LO,
    parameter int B_HI        = BANK_B_HI,
    parameter int C_LO        = BANK_C_LO,
    parameter int C_HI        = BANK_C_HI,
    parameter int RST_HOLD    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              ref_clk,
    input  logic              bypass,
    input  logic              range_sel,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_c,
    input  logic              rst_dis,
    output logic [A_OUTS-1:0] qa,
    output logic [B_OUTS-1:0] qb,
    output logic [C_OUTS-1:0] qc,
    output logic [A_OUTS-1:0] oe_a,
    output logic [B_OUTS-1:0] oe_b,
    output logic [C_OUTS-1:0] oe_c
);
    logic                   work_clk;
    logic                   qual;
    logic [SYNC_STAGES-1:0] sync;
    logic                   work_rst;
    cfg_t                   cfg;
    logic                   pre;
    logic                   tick;
    logic                   lvl_a, lvl_b, lvl_c;
    int                     div_a, div_b, div_c;

    assign work_clk = bypass ? ref_clk : src_clk;

    bcd_rst_qual #(.HOLD(RST_HOLD)) u_qual (
        .ref_clk (ref_clk),
        .rst_in  (rst_dis),
        .qual    (qual)
    );

    always_ff @(posedge work_clk) begin
        sync <= {sync[SYNC_STAGES-2:0], qual};
    end
    assign work_rst = sync[SYNC_STAGES-1];

    always_ff @(posedge work_clk) begin
        if (work_rst)
            cfg <= '{range: range_sel, sel_a: sel_a, sel_b: sel_b, sel_c: sel_c};
    end

    always_ff @(posedge work_clk) begin
        if (work_rst) pre <= 1'b0;
        else          pre <= ~pre;
    end
    assign tick = cfg.range ? pre : 1'b1;

    bcd_bank #(.OUTS(A_OUTS), .DIV_LO(A_LO), .DIV_HI(A_HI)) u_bank_a (
        .clk(work_clk), .rst(work_rst), .tick(tick), .sel(cfg.sel_a),
        .level(lvl_a), .q(qa)
    );
    bcd_bank #(.OUTS(B_OUTS), .DIV_LO(B_LO), .DIV_HI(B_HI)) u_bank_b (
        .clk(work_clk), .rst(work_rst), .tick(tick), .sel(cfg.sel_b),
        .level(lvl_b), .q(qb)
    );
    bcd_bank #(.OUTS(C_OUTS), .DIV_LO(C_LO), .DIV_HI(C_HI)) u_bank_c (
        .clk(work_clk), .rst(work_rst), .tick(tick), .sel(cfg.sel_c),
        .level(lvl_c), .q(qc)
    );

    assign oe_a = {A_OUTS{~rst_dis}};
    assign oe_b = {B_OUTS{~rst_dis}};
    assign oe_c = {C_OUTS{~rst_dis}};

    assign div_a = pick_div(cfg.sel_a, A_LO, A_HI);
    assign div_b = pick_div(cfg.sel_b, B_LO, B_HI);
    assign div_c = pick_div(cfg.sel_c, C_LO, C_HI);

    // R10
    cfg_frozen_in_run_chk: assert property (@(posedge work_clk) disable iff (work_rst)
        1'b1 |=> $stable(cfg));

    // R6
    a_rise_c_chk: assert property (@(posedge work_clk) disable iff (work_rst)
        ($rose(lvl_a) && divides(div_c, div_a)) |-> $rose(lvl_c));

    // R6
    a_rise_b_chk: assert property (@(posedge work_clk) disable iff (work_rst)
        ($rose(lvl_a) && divides(div_b, div_a)) |-> $rose(lvl_b));

    // R6
    b_rise_c_chk: assert property (@(posedge work_clk) disable iff (work_rst)
        ($rose(lvl_b) && divides(div_c, div_b)) |-> $rose(lvl_c));

    // R6
    c_rise_b_chk: assert property (@(posedge work_clk) disable iff (work_rst)
        ($rose(lvl_c) && divides(div_b, div_c)) |-> $rose(lvl_b));

endmodule

// File: tb/bank_clk_divider_bench.sv
module bank_clk_divider_bench;
    import bcd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 4 * CLK_PERIOD;
    localparam int RUN_CYCLES = 48;

    logic src_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic bypass = 1'b0, range_sel = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic rst_dis = 1'b0;
    logic [BANK_A_OUTS-1:0] qa, oe_a;
    logic [BANK_B_OUTS-1:0] qb, oe_b;
    logic [BANK_C_OUTS-1:0] qc, oe_c;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) src_clk = ~src_clk;
    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

    bank_clk_divider u_bank_clk_divider (
        .src_clk(src_clk), .ref_clk(ref_clk), .bypass(bypass),
        .range_sel(range_sel), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .rst_dis(rst_dis), .qa(qa), .qb(qb), .qc(qc),
        .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c)
    );

    function automatic int ratio_a(logic s); return s ? 6 : 4; endfunction
    function automatic int ratio_b(logic s); return s ? 2 : 4; endfunction
    function automatic int ratio_c(logic s); return s ? 4 : 2; endfunction
    function automatic logic exp_level(int n, int t); return (t % n) < (n / 2); endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic wneg();
        if (bypass) @(negedge ref_clk);
        else        @(negedge src_clk);
    endtask

    task automatic run_cfg(input logic byp, input logic rng, input logic a,
                           input logic b, input logic c, input logic disturb,
                           input logic pulse, input string tag);
        int na, nb, nc, j, t, hi_cnt, per;
        logic found;
        @(negedge ref_clk);
        rst_dis = 1'b1;
        #1;
        // R7: enables drop at once
        check(oe_a == '0 && oe_b == '0 && oe_c == '0, "R7", "oe low in reset",
              int'({oe_a, oe_b, oe_c}), 0);
        bypass = byp; range_sel = rng; sel_a = a; sel_b = b; sel_c = c;
        repeat (6) @(negedge ref_clk);
        // R7: bank clocks cleared after qualified reset
        check(qa == '0 && qb == '0 && qc == '0, "R7", "clocks low in reset",
              int'({qa, qb, qc}), 0);
        rst_dis = 1'b0;
        na = ratio_a(a); nb = ratio_b(b); nc = ratio_c(c);
        found = 1'b0;
        for (int k = 0; k < 64 && !found; k++) begin
            wneg();
            if (qa[0]) found = 1'b1;
        end
        check(found, tag, "first rise seen", int'(found), 1);
        // R6: every bank high on the same first tick
        check(&qa && &qb && &qc, "R6", "common first rise", int'({qa, qb, qc}), 2047);
        check(&oe_a && &oe_b && &oe_c, "R7", "oe high after release",
              int'({oe_a, oe_b, oe_c}), 2047);
        per = na * (rng ? 2 : 1);
        hi_cnt = 0;
        for (j = 0; j < RUN_CYCLES; j++) begin
            if (j > 0) wneg();
            if (disturb && j == 8) begin
                // R10: changes in operation are ignored
                range_sel = ~range_sel; sel_a = ~sel_a; sel_b = ~sel_b; sel_c = ~sel_c;
            end
            if (pulse && j == 10) begin
                fork
                    begin
                        @(negedge ref_clk);
                        rst_dis = 1'b1;
                        #1;
                        // R8 with R7: short pulse still drops the enables
                        check(oe_a == '0, "R8", "oe low during short pulse", int'(oe_a), 0);
                        repeat (2) @(negedge ref_clk);
                        rst_dis = 1'b0;
                    end
                join_none
            end
            t = rng ? j / 2 : j;
            if (j < per && qa[0]) hi_cnt++;
            check(qa == {BANK_A_OUTS{exp_level(na, t)}}, tag,
                  $sformatf("R2 bank A j=%0d", j), int'(qa), int'({BANK_A_OUTS{exp_level(na, t)}}));
            check(qb == {BANK_B_OUTS{exp_level(nb, t)}}, tag,
                  $sformatf("R3 bank B j=%0d", j), int'(qb), int'({BANK_B_OUTS{exp_level(nb, t)}}));
            check(qc == {BANK_C_OUTS{exp_level(nc, t)}}, tag,
                  $sformatf("R4 bank C j=%0d", j), int'(qc), int'({BANK_C_OUTS{exp_level(nc, t)}}));
        end
        // R5: half of one bank A period is high
        check(hi_cnt == per / 2, "R5", "bank A high samples per period", hi_cnt, per / 2);
        wneg();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        repeat (2) @(negedge ref_clk);
        // R10: all-zero defaults give 4, 4, 2 with no pre-division
        run_cfg(0, 0, 0, 0, 0, 0, 0, "R10");
        // R1: pre-divider by two
        run_cfg(0, 1, 0, 0, 0, 0, 0, "R1");
        run_cfg(0, 1, 1, 1, 1, 0, 0, "R1");
        run_cfg(0, 0, 1, 1, 1, 0, 0, "R2");
        // R9: reference clock as work clock
        run_cfg(1, 0, 0, 1, 0, 0, 0, "R9");
        run_cfg(1, 1, 1, 0, 1, 0, 0, "R9");
        // R10: select changes in operation
        run_cfg(0, 0, 0, 0, 1, 1, 0, "R10");
        // R8: two-edge pulse leaves the clocks running
        run_cfg(0, 0, 1, 0, 0, 0, 1, "R8");
        run_cfg(1, 0, 0, 1, 1, 0, 1, "R8");
        for (int i = 0; i < 8; i++) begin
            run_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom), "R6");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule